// File: doc/BRIEF.md
# In-System Programming Command Receiver

This block accepts byte-serial programming commands from an external host over a SPI-style link: SCK, MOSI and MISO. It turns each command into a request on a simple memory port that uses a request/acknowledge handshake. It is only awake while the target's external reset input is held low. Every command is a fixed frame of four bytes, sent most significant bit first. The block samples MOSI when SCK rises and moves MISO on when SCK falls. SCK, MOSI and the reset input are all asynchronous, so each goes through a two-flop synchroniser into the block's own clock domain. SCK edges are detected from the synchronised copy.

After the reset input goes low, the receiver is locked. It issues no memory request, and MISO stays 0 except for one confirmation echo. The host unlocks it by sending the unlock frame 0xAC, 0x53, then two bytes of any value. During the third byte of that frame, MISO plays back 0x53, so the host can confirm that its byte framing lines up. Once unlocked, the receiver accepts these commands:

- read a byte of code memory or data memory;
- write a byte of code memory or data memory;
- erase everything.

A read request goes out as soon as the third byte has arrived, and the fetched byte is shifted out during the fourth byte. Writes and the erase are issued when the fourth byte completes. Raising the reset input drops any half-received frame, resets the framing, cancels any pending request and locks the receiver again.

Top module: `isp_cmd_frontend`

## Requirements
- R1: A command is exactly four bytes, or 32 rising SCK edges, counted from the moment the reset input goes low. After the fourth byte the next rising edge starts byte one of a new frame.
- R2: MOSI is sampled on rising SCK, most significant bit first. Within a byte, MISO moves to the next bit only after a falling SCK edge. The first bit of each byte is on MISO before that byte's first rising edge.
- R3: The unlock frame (byte 0 = 0xAC, byte 1 = 0x53, bytes 2 and 3 any value) enters programming mode when its fourth byte completes, but only while the reset input is low. The same frame sent while the reset input is high has no effect.
- R4: While byte 2 of a frame whose first two bytes are 0xAC, 0x53 is being transferred, MISO carries 0x53. This happens whether or not the receiver is already unlocked.
- R5: While locked, no memory request is issued. MISO stays 0 for every byte except the R4 echo.
- R6: Read commands use opcode 0x20 for code memory and 0xA0 for data memory. The address is the low ADDR_W bits of {byte 1, byte 2}. The request (mem_op = 0) is issued after byte 2 completes, and the returned byte is shifted out on MISO during byte 3.
- R7: Write commands use opcode 0x40 for code memory and 0xC0 for data memory. The address is formed as in R6 and the data is byte 3. The request (mem_op = 1) is issued after byte 3 completes. mem_space is 0 for code memory and 1 for data memory.
- R8: A frame with byte 0 = 0xAC and bits 7:5 of byte 1 equal to 100 issues one erase request (mem_op = 2) that covers both memories. Afterwards every location reads back as 0xFF.
- R9: Each accepted command produces exactly one request. mem_req, mem_op, mem_space, mem_addr and mem_wdata hold steady until mem_ack is seen. mem_req falls on the clock edge that samples mem_ack.
- R10: Raising the reset input abandons any partial frame, clears the bit and byte counters, forces MISO to 0 and leaves programming mode.
- R11: Any other first byte, or a 0xAC frame whose byte 1 matches neither rule, is ignored. It produces no request and MISO stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Internal asynchronous reset, active low |
| tgt_rst_n | input | 1 | External reset input; the receiver is active while it is low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_op | output | 2 | 0 read, 1 write, 2 erase |
| mem_space | output | 1 | 0 code memory, 1 data memory |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ack |

## Verification
The bench sends read and write frames before unlocking. A receiver that failed to gate on the unlock would raise requests that the scoreboard does not expect, and later reads would return corrupted data. It releases the reset input partway through a frame and then resumes. A receiver that kept its byte count would misframe the next command, and one that stayed unlocked would serve a read it should refuse. It also sends the unlock frame while reset is high, and it sends erase look-alikes and unknown opcodes. A loose decoder would then issue a stray request, and a receiver with a wrong echo or read-return timing would show up as MISO bytes that are shifted by one bit or contain the wrong data.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int BYTE_BITS   = 8;
  localparam int FRAME_BYTES = 4;
  localparam int BIT_W       = $clog2(BYTE_BITS);
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  localparam logic [7:0] OPC_LEAD     = 8'hAC;
  localparam logic [7:0] OPC_UNLOCK   = 8'h53;
  localparam logic [2:0] OPC_WIPE_TAG = 3'b100;
  localparam logic [7:0] OPC_RD_CODE  = 8'h20;
  localparam logic [7:0] OPC_WR_CODE  = 8'h40;
  localparam logic [7:0] OPC_RD_DATA  = 8'hA0;
  localparam logic [7:0] OPC_WR_DATA  = 8'hC0;

  typedef enum logic [1:0] {
    MOP_READ  = 2'd0,
    MOP_WRITE = 2'd1,
    MOP_ERASE = 2'd2,
    MOP_NONE  = 2'd3
  } mem_op_e;

  typedef enum logic [2:0] {
    CK_NONE, CK_UNLOCK, CK_WIPE, CK_RD_CODE, CK_RD_DATA, CK_WR_CODE, CK_WR_DATA
  } cmd_kind_e;

  // Command kind from the first two bytes of a frame
  function automatic cmd_kind_e classify(input logic [7:0] b0, input logic [7:0] b1);
    if (b0 == OPC_LEAD) begin
      if (b1 == OPC_UNLOCK) return CK_UNLOCK;
      if (b1[7:5] == OPC_WIPE_TAG) return CK_WIPE;
      return CK_NONE;
    end
    case (b0)
      OPC_RD_CODE: return CK_RD_CODE;
      OPC_RD_DATA: return CK_RD_DATA;
      OPC_WR_CODE: return CK_WR_CODE;
      OPC_WR_DATA: return CK_WR_DATA;
      default:     return CK_NONE;
    endcase
  endfunction

  function automatic logic is_read(input cmd_kind_e k);
    return (k == CK_RD_CODE) || (k == CK_RD_DATA);
  endfunction

  function automatic logic is_write(input cmd_kind_e k);
    return (k == CK_WR_CODE) || (k == CK_WR_DATA);
  endfunction

  function automatic logic space_of(input cmd_kind_e k);
    return (k == CK_RD_DATA) || (k == CK_WR_DATA);
  endfunction
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter
  import isp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic                 sck_s,
  input  logic                 mosi_s,
  input  logic                 tx_load,
  input  logic [BYTE_BITS-1:0] tx_val,
  output logic                 miso,
  output logic                 byte_done,
  output logic [IDX_W-1:0]     byte_idx,
  output logic [BYTE_BITS-1:0] rx_byte
);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(FRAME_BYTES - 1);

  logic                 sck_q;
  logic                 sck_rise, sck_fall;
  logic [BIT_W-1:0]     bit_cnt;
  logic [IDX_W-1:0]     byte_cnt;
  logic [BYTE_BITS-2:0] rx_sh;
  logic [BYTE_BITS-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign sck_rise  = active & sck_s & ~sck_q;
  assign sck_fall  = active & ~sck_s & sck_q;
  assign byte_done = sck_rise && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
    end else if (!active) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
    end else begin
      if (sck_rise) begin
        rx_sh <= {rx_sh[BYTE_BITS-3:0], mosi_s};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt  <= '0;
          byte_cnt <= (byte_cnt == LAST_BYTE) ? '0 : byte_cnt + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      // the fall right after a byte boundary keeps the freshly loaded MSB
      if (tx_load)
        tx_sh <= tx_val;
      else if (sck_fall && (bit_cnt != '0))
        tx_sh <= {tx_sh[BYTE_BITS-2:0], 1'b0};
    end
  end

  assign rx_byte  = {rx_sh, mosi_s};
  assign byte_idx = byte_cnt;
  assign miso     = tx_sh[BYTE_BITS-1];

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bit_cnt == '0 && byte_cnt == '0 && !miso)); // R10
  AST_MISO_STEADY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && !byte_done && !tx_load) |=> $stable(miso)); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n || !active)
    (byte_done && byte_idx == LAST_BYTE) |=> (byte_idx == '0)); // R1
endmodule

// File: rtl/isp_decoder.sv
module isp_decoder
  import isp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic                 byte_done,
  input  logic [IDX_W-1:0]     byte_idx,
  input  logic [BYTE_BITS-1:0] rx_byte,
  output logic                 tx_load,
  output logic [BYTE_BITS-1:0] tx_val,
  output logic                 mem_req,
  output mem_op_e              mem_op,
  output logic                 mem_space,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [7:0]           mem_wdata,
  input  logic                 mem_ack,
  input  logic [7:0]           mem_rdata
);
  logic      prog_en;
  logic [7:0] hdr0, hdr1, mid;
  cmd_kind_e kind_q, kind_now;
  logic      rd_ack;

  function automatic logic [ADDR_W-1:0] pick_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic [15:0] w;
    w = {hi, lo};
    return w[ADDR_W-1:0];
  endfunction

  assign kind_now = classify(hdr0, rx_byte);
  assign rd_ack   = mem_req && mem_ack && (mem_op == MOP_READ);

  always_comb begin
    tx_load = active && (byte_done || rd_ack);
    tx_val  = '0;
    if (rd_ack)
      tx_val = mem_rdata;
    else if (byte_done && byte_idx == IDX_W'(1) && kind_now == CK_UNLOCK)
      tx_val = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr0 <= '0; hdr1 <= '0; mid <= '0; kind_q <= CK_NONE; prog_en <= 1'b0;
      mem_req <= 1'b0; mem_op <= MOP_NONE; mem_space <= 1'b0;
      mem_addr <= '0; mem_wdata <= '0;
    end else if (!active) begin
      hdr0 <= '0; hdr1 <= '0; mid <= '0; kind_q <= CK_NONE; prog_en <= 1'b0;
      mem_req <= 1'b0; mem_op <= MOP_NONE; mem_space <= 1'b0;
      mem_addr <= '0; mem_wdata <= '0;
    end else begin
      if (mem_req && mem_ack) mem_req <= 1'b0;
      if (byte_done) begin
        case (byte_idx)
          IDX_W'(0): hdr0 <= rx_byte;
          IDX_W'(1): begin
            hdr1   <= rx_byte;
            kind_q <= kind_now;
          end
          IDX_W'(2): begin
            mid <= rx_byte;
            if (prog_en && is_read(kind_q)) begin
              mem_req   <= 1'b1;
              mem_op    <= MOP_READ;
              mem_space <= space_of(kind_q);
              mem_addr  <= pick_addr(hdr1, rx_byte);
              mem_wdata <= '0;
            end
          end
          default: begin
            if (kind_q == CK_UNLOCK) begin
              prog_en <= 1'b1;
            end else if (prog_en && kind_q == CK_WIPE) begin
              mem_req   <= 1'b1;
              mem_op    <= MOP_ERASE;
              mem_space <= 1'b0;
              mem_addr  <= '0;
              mem_wdata <= '0;
            end else if (prog_en && is_write(kind_q)) begin
              mem_req   <= 1'b1;
              mem_op    <= MOP_WRITE;
              mem_space <= space_of(kind_q);
              mem_addr  <= pick_addr(hdr1, mid);
              mem_wdata <= rx_byte;
            end
          end
        endcase
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !active)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_op) && $stable(mem_space)
                               && $stable(mem_addr) && $stable(mem_wdata))); // R9
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req); // R9
  AST_LOCKED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(prog_en)); // R5
  AST_LOCKED_MISO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !prog_en) |-> (tx_val == 8'h00 || tx_val == OPC_UNLOCK)); // R5
  AST_RELEASE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!prog_en && !mem_req)); // R10
endmodule

// File: rtl/isp_cmd_frontend.sv
module isp_cmd_frontend
  import isp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_rst_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic              mem_space,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata
);
  logic                 trst_s, mosi_s, sck_s, active;
  logic                 tx_load, byte_done;
  logic [BYTE_BITS-1:0] tx_val, rx_byte;
  logic [IDX_W-1:0]     byte_idx;
  mem_op_e              op_q;

  isp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({tgt_rst_n, mosi, sck}),
    .q({trst_s, mosi_s, sck_s})
  );

  assign active = ~trst_s;

  isp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .active(active),
    .sck_s(sck_s), .mosi_s(mosi_s),
    .tx_load(tx_load), .tx_val(tx_val), .miso(miso),
    .byte_done(byte_done), .byte_idx(byte_idx), .rx_byte(rx_byte)
  );

  isp_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .active(active),
    .byte_done(byte_done), .byte_idx(byte_idx), .rx_byte(rx_byte),
    .tx_load(tx_load), .tx_val(tx_val),
    .mem_req(mem_req), .mem_op(op_q), .mem_space(mem_space),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  assign mem_op = op_q;
endmodule

// File: tb/test_isp_cmd_frontend.sv
module test_isp_cmd_frontend;
  localparam int ADDR_W = 10;
  localparam int HALF   = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tgt_rst_n, sck, mosi, miso;
  logic mem_req, mem_space, mem_ack;
  logic [1:0] mem_op;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  isp_cmd_frontend #(.ADDR_W(ADDR_W)) i_isp_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .tgt_rst_n(tgt_rst_n), .sck(sck), .mosi(mosi),
    .miso(miso), .mem_req(mem_req), .mem_op(mem_op), .mem_space(mem_space),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  typedef struct packed {
    logic [1:0]        op;
    logic              space;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata;
  } req_t;

  req_t exp_q[$];
  int vectors = 0, miscompares = 0;
  logic [7:0] mem_p [64], mem_d [64], shd_p [64], shd_d [64];
  bit exp_en = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  initial begin : monitor
    req_t got, want;
    bit   steady;
    mem_ack   = 1'b0;
    mem_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (mem_req === 1'b1) begin
        got = '{mem_op, mem_space, mem_addr, mem_wdata};
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected request", 32'(got), 32'h0);
        end else begin
          want = exp_q.pop_front();
          if (want.op != 2'd1) want.wdata = got.wdata;
          if (want.op == 2'd2) begin want.addr = got.addr; want.space = got.space; end
          check(got == want, "R9", "request fields", 32'(got), 32'(want));
        end
        case (got.op)
          2'd0: mem_rdata = got.space ? mem_d[got.addr[5:0]] : mem_p[got.addr[5:0]];
          2'd1: if (got.space) mem_d[got.addr[5:0]] = got.wdata;
                else           mem_p[got.addr[5:0]] = got.wdata;
          2'd2: for (int i = 0; i < 64; i++) begin mem_p[i] = 8'hFF; mem_d[i] = 8'hFF; end
          default: ;
        endcase
        steady = 1'b1;
        repeat (2) begin
          @(negedge clk);
          if ({mem_req, mem_op, mem_space, mem_addr, mem_wdata} !== {1'b1, got}) steady = 1'b0;
        end
        check(steady, "R9", "request held until ack", 32'(steady), 32'h1);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        check(mem_req == 1'b0, "R9", "request dropped after ack", 32'(mem_req), 32'h0);
      end
    end
  end

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  // driver: predicts effects, pushes expected requests, checks MISO bytes
  task automatic cmd(input logic [7:0] b0, b1, b2, b3, input string tag);
    logic [7:0] want [4];
    logic [7:0] got;
    logic [15:0] w;
    bit act;
    act = (tgt_rst_n == 1'b0);
    w = {b1, b2};
    for (int i = 0; i < 4; i++) want[i] = 8'h00;
    if (act && b0 == 8'hAC && b1 == 8'h53) want[2] = 8'h53;
    if (act && exp_en) begin
      if (b0 == 8'h20 || b0 == 8'hA0) begin
        want[3] = (b0 == 8'hA0) ? shd_d[b2[5:0]] : shd_p[b2[5:0]];
        exp_q.push_back('{2'd0, b0 == 8'hA0, w[ADDR_W-1:0], 8'h00});
      end else if (b0 == 8'h40 || b0 == 8'hC0) begin
        exp_q.push_back('{2'd1, b0 == 8'hC0, w[ADDR_W-1:0], b3});
        if (b0 == 8'hC0) shd_d[b2[5:0]] = b3; else shd_p[b2[5:0]] = b3;
      end else if (b0 == 8'hAC && b1[7:5] == 3'b100) begin
        exp_q.push_back('{2'd2, 1'b0, '0, 8'h00});
        for (int i = 0; i < 64; i++) begin shd_p[i] = 8'hFF; shd_d[i] = 8'hFF; end
      end
    end
    xfer(b0, got); check(got == want[0], tag, "MISO byte 0", 32'(got), 32'(want[0]));
    xfer(b1, got); check(got == want[1], tag, "MISO byte 1", 32'(got), 32'(want[1]));
    xfer(b2, got); check(got == want[2], tag, "MISO byte 2", 32'(got), 32'(want[2]));
    xfer(b3, got); check(got == want[3], tag, "MISO byte 3", 32'(got), 32'(want[3]));
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, tag, "expected requests outstanding", 32'(exp_q.size()), 32'h0);
    if (act && b0 == 8'hAC && b1 == 8'h53) exp_en = 1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    logic [7:0] junk;
    for (int i = 0; i < 64; i++) begin
      mem_p[i] = 8'(i * 5 + 1);  shd_p[i] = 8'(i * 5 + 1);
      mem_d[i] = 8'(i * 3 + 64); shd_d[i] = 8'(i * 3 + 64);
    end
    rst_n = 1'b0; tgt_rst_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(miso == 1'b0, "R10", "reset MISO", 32'(miso), 32'h0);
    check(mem_req == 1'b0, "R9", "reset request", 32'(mem_req), 32'h0);

    // R3: unlock while reset input high has no effect
    cmd(8'hAC, 8'h53, 8'h00, 8'h00, "R3");
    tgt_rst_n = 1'b0;
    repeat (10) @(negedge clk);
    // R5: locked receiver ignores read and write
    cmd(8'h20, 8'h00, 8'h05, 8'h00, "R5");
    cmd(8'h40, 8'h00, 8'h05, 8'h77, "R5");
    // R3/R4: unlock with echo
    cmd(8'hAC, 8'h53, 8'h12, 8'h34, "R4");
    // R6/R2: reads from both spaces
    cmd(8'h20, 8'h00, 8'h05, 8'h00, "R6");
    cmd(8'hA0, 8'h00, 8'h09, 8'h00, "R6");
    // R7: writes then read back
    cmd(8'h40, 8'h00, 8'h05, 8'hA5, "R7");
    cmd(8'h20, 8'h00, 8'h05, 8'h00, "R7");
    cmd(8'hC0, 8'h00, 8'h03, 8'h3C, "R7");
    cmd(8'hA0, 8'h00, 8'h03, 8'h00, "R7");
    cmd(8'h20, 8'h00, 8'h03, 8'h00, "R7");
    // R11: unknown opcode and near-miss erase ignored
    cmd(8'h11, 8'h00, 8'h05, 8'h99, "R11");
    cmd(8'hAC, 8'h60, 8'h00, 8'h00, "R11");
    cmd(8'h20, 8'h00, 8'h05, 8'h00, "R11");
    // R4: echo also while unlocked
    cmd(8'hAC, 8'h53, 8'h00, 8'h00, "R4");
    // R8: erase and read back both spaces
    cmd(8'hAC, 8'h80, 8'h00, 8'h00, "R8");
    cmd(8'h20, 8'h00, 8'h05, 8'h00, "R8");
    cmd(8'hA0, 8'h00, 8'h03, 8'h00, "R8");
    // R10: abort partial write by releasing reset input
    xfer(8'h40, junk);
    xfer(8'h00, junk);
    tgt_rst_n = 1'b1;
    exp_en = 0;
    repeat (10) @(negedge clk);
    check(miso == 1'b0, "R10", "MISO while released", 32'(miso), 32'h0);
    tgt_rst_n = 1'b0;
    repeat (10) @(negedge clk);
    cmd(8'h20, 8'h00, 8'h05, 8'h00, "R10");
    // R1: framing restarts cleanly after re-entry
    cmd(8'hAC, 8'h53, 8'h00, 8'h00, "R1");
    cmd(8'h20, 8'h00, 8'h05, 8'h00, "R1");
    cmd(8'hC0, 8'h01, 8'h07, 8'h5A, "R7");
    cmd(8'hA0, 8'h01, 8'h07, 8'h00, "R6");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule